// File: doc/BRIEF.md
# Magtape command and status sequencer

This block is the command and status engine of a tape controller that serves up to four drives. The host writes 8-bit command bytes addressed to one drive, and the block decides whether the command is legal and whether it can run at that moment. Once a command is accepted, the block carries the drive through a timed completion. That completion can raise up to three separate interrupts: file mark, then end of motion, then no motion. The host reads the combined controller and drive status as one byte for any drive it selects.

Tape motion is represented by per-drive inputs from a behavioural drive model. One input reports that the motion has finished, one that a file mark was crossed, and one that a fault occurred. The byte data path, the channel DMA and the tape mechanics are not part of this block. Two parameters set the delays in clock cycles. One is a short start latency, during which the motion-done input is not looked at. The other is a longer record delay that separates the completion stages.

Top module: `tape_seq`

## Requirements
- R1: Reset, and the clear command (low six bits 0x20, sent to any drive), put the controller into this state: busy set, error, end-of-file and end-of-motion clear, every drive idle and showing no-motion, and every interrupt arm cleared. Clear keeps each drive's end-of-tape flag, while reset clears it.
- R2: Only the low six bits select the function. The accepted codes are 0x11 backspace, 0x13 space file reverse, 0x21 read, 0x22 write, 0x23 space file forward, 0x30 write file mark and 0x38 rewind. Any other code leaves the state unchanged.
- R3: A legal command is ignored if its drive is offline, or if it is a write or a write file mark sent to a write-locked drive.
- R4: A command sent to a drive that is still in its motion phase is ignored. An accepted command cancels every other active drive, except a drive that is rewinding. A cancelled drive raises no further interrupt and does not set no-motion.
- R5: Accepting write or rewind clears busy. Accepting any other command sets busy. Every accepted command clears error, end-of-file and end-of-motion, and clears the addressed drive's end-of-tape and no-motion flags.
- R6: The status byte for the selected drive has these bits: 7 error, 6 end-of-file, 5 end-of-tape, 4 no-motion, 3 busy, 2 exception, 1 end-of-motion, 0 unavailable. Exception is the OR of error, end-of-file and no-motion. When the drive is offline, bits 5, 4 and 0 read 0, 0 and 1, and exception is the OR of error and end-of-file.
- R7: Motion-done is ignored for BYTE_DLY cycles after a command is accepted. The first motion-done after that starts the stop stages. REC_DLY+1 cycles later, busy clears and end-of-motion sets, with an interrupt. REC_DLY+1 cycles after that, the drive's no-motion flag sets, with a second interrupt.
- R8: Rewind finishes on motion-done in one step. It sets no-motion and end-of-tape, clears busy, does not set end-of-motion, and raises exactly one interrupt.
- R9: At motion-done, write file mark always sets end-of-file and interrupts. Read and both space-file commands do the same only when the file-mark input is high at motion-done. In both cases this happens before the stop stages.
- R10: Command bits 7:6 update the addressed drive's interrupt arm on every command write, including ignored ones: 01 arms, 10 disarms, 00 and 11 leave it unchanged. A drive's interrupt pulses for one cycle, and only while the drive is armed.
- R11: If the drive-fault input is high at motion-done, the error bit sets and stays set through the stop stages.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_we | input | 1 | Command byte write strobe |
| cmd_unit | input | SW | Drive addressed by the command |
| cmd_data | input | 8 | Command byte: arm control in 7:6, function in 5:0 |
| stat_unit | input | SW | Drive whose status is shown |
| stat_data | output | 8 | Status byte for stat_unit |
| unit_online | input | NDRV | Drive attached |
| unit_wlock | input | NDRV | Drive write-locked |
| unit_done | input | NDRV | Drive reports motion finished |
| unit_mark | input | NDRV | Drive crossed a file mark |
| unit_fault | input | NDRV | Drive reports a fault |
| irq | output | NDRV | One-cycle interrupt pulse per drive |

## Verification
Most internal faults show up at the status byte within one cycle, and the rest within a few record delays. A wrong accept decision shows on the cycle after the command write: busy has the wrong value, or the no-motion or end-of-tape bits fail to clear. A wrong stage counter moves the cycle in which end-of-motion or no-motion first appears, so the bench measures those cycles exactly. A wrong cancel or arm decision shows as an interrupt pulse that appears or goes missing on a drive's line within about two record delays.

// File: rtl/tape_seq.sv
module tape_seq #(
  parameter int NDRV = 4,
  parameter int REC_DLY = 16,
  parameter int BYTE_DLY = 3,
  localparam int SW = (NDRV > 1) ? $clog2(NDRV) : 1,
  localparam int TMAX = (REC_DLY > BYTE_DLY) ? REC_DLY : BYTE_DLY,
  localparam int TW = $clog2(TMAX + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cmd_we,
  input  logic [SW-1:0]   cmd_unit,
  input  logic [7:0]      cmd_data,
  input  logic [SW-1:0]   stat_unit,
  output logic [7:0]      stat_data,
  input  logic [NDRV-1:0] unit_online,
  input  logic [NDRV-1:0] unit_wlock,
  input  logic [NDRV-1:0] unit_done,
  input  logic [NDRV-1:0] unit_mark,
  input  logic [NDRV-1:0] unit_fault,
  output logic [NDRV-1:0] irq
);

  localparam logic [5:0] OP_BSP = 6'h11;
  localparam logic [5:0] OP_SFR = 6'h13;
  localparam logic [5:0] OP_CLR = 6'h20;
  localparam logic [5:0] OP_RD  = 6'h21;
  localparam logic [5:0] OP_WR  = 6'h22;
  localparam logic [5:0] OP_SFF = 6'h23;
  localparam logic [5:0] OP_WFM = 6'h30;
  localparam logic [5:0] OP_REW = 6'h38;

  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_EOM, ST_NMT} stage_t;

  stage_t          stage [NDRV];
  logic [5:0]      op    [NDRV];
  logic [TW-1:0]   tmr   [NDRV];
  logic            s_err, s_eof, s_busy, s_eom;
  logic [NDRV-1:0] eot, nmtn, arm, arm_nx, irq_q, mover;

  wire [5:0] cfn     = cmd_data[5:0];
  wire       is_clr  = cmd_we && (cfn == OP_CLR);
  wire       wr_kind = (cfn == OP_WR) || (cfn == OP_WFM);
  wire       code_ok = (cfn == OP_BSP) || (cfn == OP_SFR) || (cfn == OP_RD) ||
                       (cfn == OP_WR)  || (cfn == OP_SFF) || (cfn == OP_WFM) ||
                       (cfn == OP_REW);
  wire       accept  = cmd_we && !is_clr && code_ok && unit_online[cmd_unit] &&
                       !(wr_kind && unit_wlock[cmd_unit]) &&
                       (stage[cmd_unit] != ST_RUN);

  always_comb begin
    arm_nx = arm;
    if (cmd_we) begin
      case (cmd_data[7:6])
        2'b01:   arm_nx[cmd_unit] = 1'b1;
        2'b10:   arm_nx[cmd_unit] = 1'b0;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s_err  <= 1'b0;
      s_eof  <= 1'b0;
      s_eom  <= 1'b0;
      s_busy <= 1'b1;
      arm    <= '0;
      eot    <= '0;
      nmtn   <= '1;
      irq_q  <= '0;
      for (int i = 0; i < NDRV; i++) begin
        stage[i] <= ST_IDLE;
        op[i]    <= '0;
        tmr[i]   <= '0;
      end
    end else begin
      irq_q <= '0;
      arm   <= arm_nx;
      for (int i = 0; i < NDRV; i++) begin
        case (stage[i])
          ST_RUN: begin
            if (tmr[i] != '0) tmr[i] <= tmr[i] - 1'b1;
            else if (unit_done[i]) begin
              if (op[i] == OP_REW) begin
                stage[i] <= ST_IDLE;
                eot[i]   <= 1'b1;
                nmtn[i]  <= 1'b1;
                s_busy   <= 1'b0;
                if (arm[i]) irq_q[i] <= 1'b1;
              end else begin
                if (unit_fault[i]) s_err <= 1'b1;
                if ((op[i] == OP_WFM) ||
                    (unit_mark[i] && ((op[i] == OP_SFF) || (op[i] == OP_SFR) ||
                                      (op[i] == OP_RD)))) begin
                  s_eof <= 1'b1;
                  if (arm[i]) irq_q[i] <= 1'b1;
                end
                stage[i] <= ST_EOM;
                tmr[i]   <= TW'(REC_DLY);
              end
            end
          end
          ST_EOM: begin
            if (tmr[i] != '0) tmr[i] <= tmr[i] - 1'b1;
            else begin
              s_busy   <= 1'b0;
              s_eom    <= 1'b1;
              stage[i] <= ST_NMT;
              tmr[i]   <= TW'(REC_DLY);
              if (arm[i]) irq_q[i] <= 1'b1;
            end
          end
          ST_NMT: begin
            if (tmr[i] != '0) tmr[i] <= tmr[i] - 1'b1;
            else begin
              nmtn[i]  <= 1'b1;
              stage[i] <= ST_IDLE;
              if (arm[i]) irq_q[i] <= 1'b1;
            end
          end
          default: ;
        endcase
      end

      if (is_clr) begin
        s_busy <= 1'b1;
        s_err  <= 1'b0;
        s_eof  <= 1'b0;
        s_eom  <= 1'b0;
        arm    <= '0;
        nmtn   <= '1;
        irq_q  <= '0;
        for (int i = 0; i < NDRV; i++) stage[i] <= ST_IDLE;
      end else if (accept) begin
        for (int i = 0; i < NDRV; i++)
          if ((i != int'(cmd_unit)) && (stage[i] != ST_IDLE) && (op[i] != OP_REW))
            stage[i] <= ST_IDLE;
        stage[cmd_unit] <= ST_RUN;
        op[cmd_unit]    <= cfn;
        tmr[cmd_unit]   <= TW'(BYTE_DLY);
        eot[cmd_unit]   <= 1'b0;
        nmtn[cmd_unit]  <= 1'b0;
        s_busy <= !((cfn == OP_WR) || (cfn == OP_REW));
        s_err  <= 1'b0;
        s_eof  <= 1'b0;
        s_eom  <= 1'b0;
      end
    end
  end

  assign irq = irq_q;

  wire sel_on = unit_online[stat_unit];
  assign stat_data = sel_on ?
    {s_err, s_eof, eot[stat_unit], nmtn[stat_unit], s_busy,
     s_err | s_eof | nmtn[stat_unit], s_eom, 1'b0} :
    {s_err, s_eof, 2'b00, s_busy, s_err | s_eof, s_eom, 1'b1};

  always_comb
    for (int i = 0; i < NDRV; i++)
      mover[i] = (stage[i] != ST_IDLE) && (op[i] != OP_REW);

  a_r4_single_mover: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(mover) <= 1);

  a_r7_eom_not_busy: assert property (@(posedge clk) disable iff (!rst_n)
    s_eom |-> !s_busy);

  for (genvar g = 0; g < NDRV; g++) begin : g_chk
    a_r10_irq_needs_arm: assert property (@(posedge clk) disable iff (!rst_n)
      irq_q[g] |-> $past(arm[g]));
    a_r8_eot_with_nmtn: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(eot[g]) |-> nmtn[g]);
  end

endmodule

// File: tb/tape_seq_tb.sv
`timescale 1ns/1ps
module tape_seq_tb;
  localparam int NDRV = 4;
  localparam int RD   = 16;
  localparam int BD   = 3;
  localparam int T_EOF = BD + 2;
  localparam int T_EOM = BD + RD + 3;
  localparam int T_NMT = BD + 2 * RD + 4;

  logic clk = 0, rst_n = 0, cmd_we = 0;
  logic [1:0] cmd_unit = 0, stat_unit = 0;
  logic [7:0] cmd_data = 0;
  logic [7:0] stat_data;
  logic [NDRV-1:0] unit_online = 4'b0111, unit_wlock = 4'b0100;
  logic [NDRV-1:0] unit_done = 4'b1111, unit_mark = 0, unit_fault = 0;
  logic [NDRV-1:0] irq;

  int nchk = 0, nerr = 0;
  int fe, fn, ff, ni;

  always #4 clk = ~clk;

  tape_seq #(.NDRV(NDRV), .REC_DLY(RD), .BYTE_DLY(BD)) u_dut (
    .clk(clk), .rst_n(rst_n), .cmd_we(cmd_we), .cmd_unit(cmd_unit),
    .cmd_data(cmd_data), .stat_unit(stat_unit), .stat_data(stat_data),
    .unit_online(unit_online), .unit_wlock(unit_wlock), .unit_done(unit_done),
    .unit_mark(unit_mark), .unit_fault(unit_fault), .irq(irq));

  // {drive, command, expected status one cycle after the write}
  localparam logic [17:0] VEC [16] = '{
    {2'd0, 8'h21, 8'h08}, {2'd0, 8'h22, 8'h00}, {2'd1, 8'h38, 8'h00},
    {2'd0, 8'h15, 8'h1C}, {2'd2, 8'h22, 8'h1C}, {2'd2, 8'h30, 8'h1C},
    {2'd2, 8'h21, 8'h08}, {2'd3, 8'h21, 8'h09}, {2'd0, 8'h3F, 8'h1C},
    {2'd0, 8'h00, 8'h1C}, {2'd0, 8'h11, 8'h08}, {2'd0, 8'h13, 8'h08},
    {2'd0, 8'h23, 8'h08}, {2'd1, 8'h30, 8'h08}, {2'd0, 8'h61, 8'h08},
    {2'd0, 8'h12, 8'h1C}};

  task automatic chk(input string req, input int act, input int exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic issue(input logic [1:0] d, input logic [7:0] c);
    @(negedge clk);
    cmd_we = 1; cmd_unit = d; cmd_data = c;
    @(negedge clk);
    cmd_we = 0;
  endtask

  task automatic watch(input logic [1:0] d, input int n);
    fe = 0; fn = 0; ff = 0; ni = 0;
    for (int c = 1; c <= n; c++) begin
      if (stat_data[1] && fe == 0) fe = c;
      if (stat_data[4] && fn == 0) fn = c;
      if (stat_data[6] && ff == 0) ff = c;
      if (irq[d]) ni++;
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nerr++; nchk++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    stat_unit = 0; #1 chk("R1 reset status online", stat_data, 8'h1C);
    stat_unit = 3; #1 chk("R6 offline status", stat_data, 8'h09);
    chk("R1 no irq after reset", irq, 0);

    for (int v = 0; v < 16; v++) begin
      issue(0, 8'h20);
      stat_unit = VEC[v][17:16];
      issue(VEC[v][17:16], VEC[v][15:8]);
      chk($sformatf("R2 R3 R5 vector %0d", v), stat_data, VEC[v][7:0]);
    end

    // R7 read, armed
    issue(0, 8'h20); stat_unit = 0;
    issue(0, 8'h61); watch(0, 60);
    chk("R7 eom cycle", fe, T_EOM);
    chk("R7 nmtn cycle", fn, T_NMT);
    chk("R7 irq count", ni, 2);
    chk("R7 final status", stat_data, 8'h16);

    // R8 rewind, armed
    issue(0, 8'h20); stat_unit = 1;
    issue(1, 8'h78); watch(1, 60);
    chk("R8 nmtn cycle", fn, T_EOF);
    chk("R8 no eom", fe, 0);
    chk("R8 irq count", ni, 1);
    chk("R8 final status", stat_data, 8'h34);

    // R9 write file mark
    issue(0, 8'h20); stat_unit = 0;
    issue(0, 8'h70); watch(0, 60);
    chk("R9 wfm eof cycle", ff, T_EOF);
    chk("R9 wfm eom cycle", fe, T_EOM);
    chk("R9 wfm irq count", ni, 3);
    chk("R9 wfm final", stat_data, 8'h56);

    // R9 space forward with and without mark
    issue(0, 8'h20); unit_mark[0] = 1;
    issue(0, 8'h63); watch(0, 60);
    chk("R9 sff mark eof", ff, T_EOF);
    chk("R9 sff mark irqs", ni, 3);
    unit_mark[0] = 0;
    issue(0, 8'h20);
    issue(0, 8'h63); watch(0, 60);
    chk("R9 sff no mark eof", ff, 0);
    chk("R9 sff no mark irqs", ni, 2);

    // R11 fault
    issue(0, 8'h20); unit_fault[0] = 1;
    issue(0, 8'h61); watch(0, 60);
    unit_fault[0] = 0;
    chk("R11 fault final", stat_data, 8'h96);

    // R10 arm control
    issue(0, 8'h20);
    issue(0, 8'h61); watch(0, 60);
    chk("R10 armed irqs", ni, 2);
    issue(0, 8'h21); watch(0, 60);
    chk("R10 unchanged irqs", ni, 2);
    issue(0, 8'hA1); watch(0, 60);
    chk("R10 disarmed irqs", ni, 0);
    chk("R10 disarmed still completes", fn, T_NMT);

    // R4 ignore while running, cancel other drive
    issue(0, 8'h20); unit_done[0] = 0; stat_unit = 0;
    issue(0, 8'h61);
    issue(0, 8'h22);
    chk("R4 write ignored while running", stat_data & 8'h08, 8'h08);
    issue(1, 8'h21);
    unit_done[0] = 1;
    watch(0, 60);
    chk("R4 cancelled drive no irq", ni, 0);
    chk("R4 cancelled drive no nmtn", fn, 0);

    // R4 rewind survives another command
    issue(0, 8'h20); unit_done[1] = 0; stat_unit = 1;
    issue(1, 8'h78);
    issue(0, 8'h21);
    unit_done[1] = 1;
    watch(1, 60);
    chk("R4 rewind irq kept", ni, 1);
    chk("R4 rewind completes", stat_data & 8'h30, 8'h30);

    // R1 clear keeps eot and disarms
    issue(0, 8'h20);
    chk("R1 clear keeps eot", stat_data, 8'h3C);
    issue(1, 8'h21); watch(1, 60);
    chk("R1 clear disarmed", ni, 0);

    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule